// File: doc/BRIEF.md
# Stage-Skipping Multi-Cycle Processor Core

This block is a small 32-bit processor core that runs one instruction at a time and spends exactly one clock cycle in each stage it visits. The five possible stages are fetch, decode with register read, execute, memory access and register write-back. The control sequence for each instruction visits only the stages it needs. Register add and set-less-than-immediate skip the memory stage. A store ends in the memory stage. A load is the one instruction that visits all five. An unsupported word ends right after decode. Values pass from stage to stage through holding registers.

The core contains its own program counter, a 32-entry register file, the ALU, the stage controller and two small word-addressed memories, one for instructions and one for data. A preload port fills either memory, normally while reset is held. A debug port reads any register combinationally, shows the current stage, and gives a one-cycle retire pulse at the end of every instruction. Software or a testbench can use that pulse to count cycles per instruction.

Top module: `msk_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and the stage to fetch, stage code 0, with retire low. Stage codes are: 0 fetch, 1 decode, 2 execute, 3 memory, 4 write-back.
- R2: Fetch reads the instruction word at byte address PC, using word index PC[7:2] with the default depth, and adds 4 to PC. Instructions therefore run in order from address 0.
- R3: Register add uses opcode bits [31:26]=0x00 and funct bits [5:0]=0x20, with rs in [25:21], rt in [20:16] and rd in [15:11]. It writes rs+rt (modulo 2^32) into rd and retires in the write-back stage 4 cycles after its fetch cycle began.
- R4: Set-less-than-immediate uses opcode 0x0A. It writes 1 into rt when rs is less than the sign-extended immediate in bits [15:0] under a signed comparison, and writes 0 otherwise. It retires in write-back after 4 cycles.
- R5: Load word uses opcode 0x23. It reads data memory at the byte address rs plus the sign-extended immediate and writes the word into rt. It retires in write-back after 5 cycles.
- R6: Store word uses opcode 0x2B. It writes rt into data memory at the byte address rs plus the sign-extended immediate. It writes no register, and it retires in the memory stage after 4 cycles.
- R7: Register 0 always reads as zero, and writes that target it are dropped.
- R8: Any other opcode, or opcode 0 with a funct other than 0x20, changes no register and no memory word. It retires in the decode stage after 2 cycles.
- R9: Retire is high for exactly one cycle per instruction, in that instruction's last stage.
- R10: When an instruction's destination is also one of its sources, the sources hold the values from before the write.
- R11: While the preload enable is high, the preload word is written at the preload word index, into data memory when the select is 1 and into instruction memory when it is 0.
- R12: The debug read port returns the selected register in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Preload write enable |
| ld_dmem | input | 1 | Preload target: 1 data memory, 0 instruction memory |
| ld_addr | input | LD_ADDR_W (16) | Preload word index |
| ld_data | input | XLEN (32) | Preload word |
| dbg_raddr | input | 5 | Debug register select |
| dbg_rdata | output | XLEN (32) | Debug register value, combinational |
| dbg_stage | output | 3 | Current stage code |
| retire | output | 1 | One-cycle pulse in an instruction's last stage |

## Verification
The stage code and the retire pulse are decoded from the stage register, so both change one edge after the transition that causes them. The bench therefore samples 1 ns after each falling edge and counts the cycles since the previous retire, starting with the fetch cycle that follows reset release. The counts it expects are 4 for add, set-less-than-immediate and store, 5 for load and 2 for an unsupported word. With each count it also checks the stage code seen at retire. Register results become visible after the edge that closes write-back, and store results only through a later load. For that reason register contents are read through the combinational debug port once the program has ended and reset is held again, and every stored word is loaded back into a spare register before that read.

// File: rtl/msk_pkg.sv
package msk_pkg;

   typedef enum logic [2:0] {
      ST_FETCH  = 3'd0,
      ST_DECODE = 3'd1,
      ST_EXEC   = 3'd2,
      ST_MEM    = 3'd3,
      ST_WB     = 3'd4
   } stage_t;

   typedef enum logic [2:0] {
      K_NOP  = 3'd0,
      K_ADD  = 3'd1,
      K_SLTI = 3'd2,
      K_LW   = 3'd3,
      K_SW   = 3'd4
   } kind_t;

   localparam logic [5:0] OPC_RTYPE = 6'h00;
   localparam logic [5:0] FUN_ADD   = 6'h20;
   localparam logic [5:0] OPC_SLTI  = 6'h0A;
   localparam logic [5:0] OPC_LW    = 6'h23;
   localparam logic [5:0] OPC_SW    = 6'h2B;

   function automatic kind_t classify(input logic [31:0] w);
      kind_t k;
      case (w[31:26])
         OPC_RTYPE: k = (w[5:0] == FUN_ADD) ? K_ADD : K_NOP;
         OPC_SLTI:  k = K_SLTI;
         OPC_LW:    k = K_LW;
         OPC_SW:    k = K_SW;
         default:   k = K_NOP;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/msk_wordmem.sv
module msk_wordmem #(
   parameter int WORDS = 64,
   parameter int W     = 32,
   localparam int AW   = $clog2(WORDS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [W-1:0]  wdata,
   input  logic [AW-1:0] raddr,
   output logic [W-1:0]  rdata
);
   logic [W-1:0] cells [WORDS];

   always_ff @(posedge clk) begin
      if (we) cells[waddr] <= wdata;
   end

   assign rdata = cells[raddr];

   p_write_lands_r11: assert property (@(posedge clk)
      we |=> cells[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/msk_regfile.sv
module msk_regfile #(
   parameter int NREGS = 32,
   parameter int W     = 32,
   localparam int AW   = $clog2(NREGS)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   output logic [W-1:0]  rd1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd2,
   input  logic [AW-1:0] ra3,
   output logic [W-1:0]  rd3
);
   logic [W-1:0] q [NREGS];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_flop
         always_ff @(posedge clk) begin
            if (we && wa == AW'(i)) q[i] <= wd;
         end
      end
   end

   assign rd1 = q[ra1];
   assign rd2 = q[ra2];
   assign rd3 = q[ra3];

   p_zero_stays_r7: assert property (@(posedge clk)
      (we && wa == '0) |=> q[0] == '0);
   p_write_visible_r10: assert property (@(posedge clk)
      (we && wa != '0) |=> q[$past(wa)] == $past(wd));
endmodule

// File: rtl/msk_alu.sv
module msk_alu #(
   parameter int W = 32
) (
   input  logic         sel_slt,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   logic [W-1:0] sum;
   logic         lt;

   assign sum = a + b;
   assign lt  = $signed(a) < $signed(b);
   assign y   = sel_slt ? {{(W-1){1'b0}}, lt} : sum;

   always_comb begin
      if (sel_slt) assert (y[W-1:1] == '0);
   end
endmodule

// File: rtl/msk_ctrl.sv
module msk_ctrl
   import msk_pkg::*;
(
   input  logic   clk,
   input  logic   rst,
   input  kind_t  kind,
   output stage_t stage,
   output logic   retire
);
   stage_t nxt;

   always_comb begin
      case (stage)
         ST_FETCH:  nxt = ST_DECODE;
         ST_DECODE: nxt = (kind == K_NOP) ? ST_FETCH : ST_EXEC;
         ST_EXEC:   nxt = (kind == K_LW || kind == K_SW) ? ST_MEM : ST_WB;
         ST_MEM:    nxt = (kind == K_LW) ? ST_WB : ST_FETCH;
         ST_WB:     nxt = ST_FETCH;
         default:   nxt = ST_FETCH;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) stage <= ST_FETCH;
      else     stage <= nxt;
   end

   assign retire = (stage == ST_WB)
                || (stage == ST_MEM && kind == K_SW)
                || (stage == ST_DECODE && kind == K_NOP);

   p_reset_to_fetch_r1: assert property (@(posedge clk)
      rst |=> stage == ST_FETCH);
   p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (rst)
      stage == ST_FETCH |=> stage == ST_DECODE);
   p_nop_skips_r8: assert property (@(posedge clk) disable iff (rst)
      (stage == ST_DECODE && kind == K_NOP) |=> stage == ST_FETCH);
   p_mem_only_ldst_r6: assert property (@(posedge clk) disable iff (rst)
      stage == ST_MEM |-> (kind == K_LW || kind == K_SW));
   p_retire_single_r9: assert property (@(posedge clk) disable iff (rst)
      retire |=> !retire);
endmodule

// File: rtl/msk_core.sv
module msk_core
   import msk_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int NREGS      = 32,
   parameter int IMEM_WORDS = 64,
   parameter int DMEM_WORDS = 64,
   parameter int LD_ADDR_W  = 16
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     ld_en,
   input  logic                     ld_dmem,
   input  logic [LD_ADDR_W-1:0]     ld_addr,
   input  logic [XLEN-1:0]          ld_data,
   input  logic [$clog2(NREGS)-1:0] dbg_raddr,
   output logic [XLEN-1:0]          dbg_rdata,
   output logic [2:0]               dbg_stage,
   output logic                     retire
);
   localparam int IA_W = $clog2(IMEM_WORDS);
   localparam int DA_W = $clog2(DMEM_WORDS);
   localparam int RA_W = $clog2(NREGS);

   if (XLEN != 32) begin : g_bad_xlen
      $error("msk_core: XLEN must be 32 for the fixed encodings");
   end
   if (NREGS != 32) begin : g_bad_nregs
      $error("msk_core: NREGS must be 32 to match 5-bit register fields");
   end
   if ((1 << IA_W) != IMEM_WORDS || IA_W < 1) begin : g_bad_imem
      $error("msk_core: IMEM_WORDS must be a power of two of at least 2");
   end
   if ((1 << DA_W) != DMEM_WORDS || DA_W < 1) begin : g_bad_dmem
      $error("msk_core: DMEM_WORDS must be a power of two of at least 2");
   end
   if (LD_ADDR_W < IA_W || LD_ADDR_W < DA_W) begin : g_bad_ldw
      $error("msk_core: LD_ADDR_W too narrow for a memory index");
   end

   logic [XLEN-1:0] pc, ir, a_q, b_q, alu_q, mdr_q;
   stage_t          stage;
   kind_t           kind;

   assign kind = classify(ir);

   // instruction fields
   logic [RA_W-1:0] f_rs, f_rt, f_rd;
   logic [XLEN-1:0] imm_sx;
   assign f_rs   = ir[25:21];
   assign f_rt   = ir[20:16];
   assign f_rd   = ir[15:11];
   assign imm_sx = {{(XLEN-16){ir[15]}}, ir[15:0]};

   msk_ctrl u_ctrl (
      .clk    (clk),
      .rst    (rst),
      .kind   (kind),
      .stage  (stage),
      .retire (retire)
   );
   assign dbg_stage = stage;

   // instruction memory
   logic [XLEN-1:0] imem_rdata;
   msk_wordmem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
      .clk   (clk),
      .we    (ld_en && !ld_dmem),
      .waddr (ld_addr[IA_W-1:0]),
      .wdata (ld_data),
      .raddr (pc[IA_W+1:2]),
      .rdata (imem_rdata)
   );

   // data memory: preload has priority over the core's store
   logic            st_fire, dm_we;
   logic [DA_W-1:0] dm_waddr;
   logic [XLEN-1:0] dm_wdata, dmem_rdata;
   assign st_fire  = (stage == ST_MEM) && (kind == K_SW) && !rst;
   assign dm_we    = (ld_en && ld_dmem) || st_fire;
   assign dm_waddr = (ld_en && ld_dmem) ? ld_addr[DA_W-1:0] : alu_q[DA_W+1:2];
   assign dm_wdata = (ld_en && ld_dmem) ? ld_data : b_q;

   msk_wordmem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_waddr),
      .wdata (dm_wdata),
      .raddr (alu_q[DA_W+1:2]),
      .rdata (dmem_rdata)
   );

   // register file
   logic            rf_we;
   logic [RA_W-1:0] rf_wa;
   logic [XLEN-1:0] rf_wd, rf_rd1, rf_rd2;
   assign rf_we = (stage == ST_WB) && !rst;
   assign rf_wa = (kind == K_ADD) ? f_rd : f_rt;
   assign rf_wd = (kind == K_LW) ? mdr_q : alu_q;

   msk_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
      .clk (clk),
      .we  (rf_we),
      .wa  (rf_wa),
      .wd  (rf_wd),
      .ra1 (f_rs),
      .rd1 (rf_rd1),
      .ra2 (f_rt),
      .rd2 (rf_rd2),
      .ra3 (dbg_raddr),
      .rd3 (dbg_rdata)
   );

   // ALU
   logic [XLEN-1:0] alu_b, alu_y;
   assign alu_b = (kind == K_ADD) ? b_q : imm_sx;
   msk_alu #(.W(XLEN)) u_alu (
      .sel_slt (kind == K_SLTI),
      .a       (a_q),
      .b       (alu_b),
      .y       (alu_y)
   );

   // stage holding registers
   always_ff @(posedge clk) begin
      if (rst) begin
         pc <= '0;
      end else begin
         case (stage)
            ST_FETCH: begin
               ir <= imem_rdata;
               pc <= pc + XLEN'(4);
            end
            ST_DECODE: begin
               if (kind != K_NOP) a_q <= rf_rd1;
               if (kind == K_ADD || kind == K_SW) b_q <= rf_rd2;
            end
            ST_EXEC: alu_q <= alu_y;
            ST_MEM:  if (kind == K_LW) mdr_q <= dmem_rdata;
            default: ;
         endcase
      end
   end

   p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
      stage == ST_FETCH |=> pc == $past(pc) + XLEN'(4));
   p_rf_write_only_wb_r6: assert property (@(posedge clk) disable iff (rst)
      rf_we |-> (stage == ST_WB && kind != K_SW && kind != K_NOP));
   p_ir_held_r3: assert property (@(posedge clk) disable iff (rst)
      stage != ST_FETCH |=> $stable(ir));
endmodule

// File: tb/msk_core_test.sv
`timescale 1ns/1ps
module msk_core_test;
   logic        clk = 0;
   logic        rst = 1;
   logic        ld_en = 0, ld_dmem = 0;
   logic [15:0] ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic [4:0]  dbg_raddr = '0;
   logic [31:0] dbg_rdata;
   logic [2:0]  dbg_stage;
   logic        retire;

   always #4 clk = ~clk;

   msk_core uut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_dmem(ld_dmem),
      .ld_addr(ld_addr), .ld_data(ld_data), .dbg_raddr(dbg_raddr),
      .dbg_rdata(dbg_rdata), .dbg_stage(dbg_stage), .retire(retire)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   logic [31:0] prog [64];
   logic [31:0] dinit [64];
   logic [31:0] xreg [32];
   logic [31:0] xmem [64];
   int          xcyc [64];
   int          xstg [64];
   string       xtag [64];
   int          n = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
      return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   // bench reference model: records word, expected cycles, stage and state
   task automatic emit(input logic [31:0] w);
      logic [5:0]  op = w[31:26];
      int          rs = int'(w[25:21]), rt = int'(w[20:16]), rd = int'(w[15:11]);
      logic [31:0] sx = {{16{w[15]}}, w[15:0]};
      logic [31:0] ad;
      prog[n] = w;
      if (op == 6'h00 && w[5:0] == 6'h20) begin
         if (rd != 0) xreg[rd] = xreg[rs] + xreg[rt];
         xcyc[n] = 4; xstg[n] = 4; xtag[n] = "R3";
      end else if (op == 6'h0A) begin
         if (rt != 0) xreg[rt] = ($signed(xreg[rs]) < $signed(sx)) ? 32'd1 : 32'd0;
         xcyc[n] = 4; xstg[n] = 4; xtag[n] = "R4";
      end else if (op == 6'h23) begin
         ad = xreg[rs] + sx;
         if (rt != 0) xreg[rt] = xmem[ad[7:2]];
         xcyc[n] = 5; xstg[n] = 4; xtag[n] = "R5";
      end else if (op == 6'h2B) begin
         ad = xreg[rs] + sx;
         xmem[ad[7:2]] = xreg[rt];
         xcyc[n] = 4; xstg[n] = 3; xtag[n] = "R6";
      end else begin
         xcyc[n] = 2; xstg[n] = 1; xtag[n] = "R8";
      end
      n++;
   endtask

   initial begin
      #(8 * 20000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed, cnt, k;
      seed = $urandom(32'd2024);
      for (int i = 0; i < 32; i++) xreg[i] = '0;
      for (int i = 0; i < 64; i++) begin
         dinit[i] = $urandom;
         prog[i]  = 32'hFC00_0000;
      end
      dinit[9]  = 32'hFFFF_FFF0;
      dinit[15] = 32'd64;
      for (int i = 0; i < 64; i++) xmem[i] = dinit[i];

      // R11: preloaded values reach registers r1..r15 and base r20
      for (int r = 1; r < 16; r++) emit(enc_i(6'h23, 0, r, 16'(4 * r)));
      emit(enc_i(6'h23, 0, 20, 16'd60));
      // directed corners
      emit(enc_i(6'h0A, 9, 10, 16'hFFF1));         // R4 -16 < -15 -> 1
      emit(enc_i(6'h0A, 9, 11, 16'hFFF0));         // R4 -16 < -16 -> 0
      emit(enc_i(6'h0A, 0, 12, 16'h7FFF));         // R4 0 < 32767 -> 1
      emit(enc_r(3, 3, 3, 6'h20));                 // R10 same source and destination
      emit(enc_r(1, 2, 0, 6'h20));                 // R7 write to r0 dropped
      emit(enc_i(6'h0A, 0, 0, 16'h0005));          // R7 write to r0 dropped
      emit(enc_i(6'h2B, 20, 4, 16'd8));            // R6 positive offset
      emit(enc_i(6'h2B, 20, 5, 16'hFFF8));         // R6 negative offset
      emit(enc_i(6'h23, 20, 13, 16'd8));           // R5
      emit(enc_i(6'h23, 20, 14, 16'hFFF8));        // R5
      emit(32'hFC00_0000 | enc_i(6'h00, 1, 1, 16'h0)); // R8 unknown opcode
      emit(enc_r(1, 2, 6, 6'h22));                 // R8 R-type other funct
      // constrained random
      for (int i = 0; i < 18; i++) begin
         int sel = int'($urandom % 5);
         int a = int'($urandom % 16), b = int'($urandom % 16), c = int'($urandom % 16);
         case (sel)
            0: emit(enc_r(a, b, c, 6'h20));
            1: emit(enc_i(6'h0A, a, b, 16'($urandom)));
            2: emit(enc_i(6'h2B, 0, b, 16'(4 * (32 + $urandom % 11))));
            3: emit(enc_i(6'h23, 0, b, 16'(4 * (32 + $urandom % 11))));
            default: emit(32'hFC00_0000 | 32'($urandom % 1024));
         endcase
      end
      // read back store area into spare registers
      for (int i = 0; i < 11; i++) emit(enc_i(6'h23, 0, 21 + i, 16'(4 * (32 + i))));

      // preload during reset
      for (int i = 0; i < 64; i++) begin
         @(negedge clk);
         ld_en = 1; ld_dmem = 0; ld_addr = 16'(i); ld_data = prog[i];
         @(negedge clk);
         ld_dmem = 1; ld_data = dinit[i];
      end
      @(negedge clk);
      ld_en = 0; ld_dmem = 0;
      @(negedge clk);
      #1;
      chk(dbg_stage == 3'd0, "R1 stage in reset", 32'(dbg_stage), 32'd0);
      chk(retire == 1'b0, "R1 retire in reset", 32'(retire), 32'd0);

      // run; count cycles from the fetch cycle to each retire
      @(negedge clk);
      rst = 0;
      cnt = 0; k = 0;
      while (k < n) begin
         #1;
         cnt++;
         if (retire) begin
            chk(cnt == xcyc[k], {xtag[k], " R2 R9 cycles to retire"}, 32'(cnt), 32'(xcyc[k]));
            chk(int'(dbg_stage) == xstg[k], {xtag[k], " stage at retire"}, 32'(dbg_stage), 32'(xstg[k]));
            k++; cnt = 0;
         end else if (cnt > 8) begin
            chk(1'b0, {xtag[k], " R9 no retire"}, 32'(cnt), 32'(xcyc[k]));
            k++; cnt = 0;
         end
         @(negedge clk);
      end
      rst = 1;
      @(negedge clk);
      @(negedge clk);

      // register contents via debug port (R12), covering R3 R4 R5 R6 R7 R10
      for (int r = 0; r < 32; r++) begin
         if (r < 16 || r >= 20) begin
            dbg_raddr = 5'(r);
            #1;
            chk(dbg_rdata === xreg[r], $sformatf("R12 R3 R4 R5 R6 R7 R10 reg %0d", r), dbg_rdata, xreg[r]);
            #1;
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule